// File: doc/BRIEF.md
# Translated DMA Channel Engine

This block runs device transfers for several DMA channels and moves them through a page translation table held in system memory. Software programs each channel with a flag word, a byte count and a logical start address, and it sets a table base and a table limit. A device then posts a request that names a channel, a direction and a length. The engine checks that the request agrees with the channel setup and clamps the length to the channel count. It then walks the logical range one 4 KiB page at a time. For each page it fetches an 8-byte translation entry and issues one data burst to the translated physical address.

The engine is built around one state machine.
- `ST_IDLE` accepts a request. A request with a disabled channel or the wrong direction is refused and the machine stays in `ST_IDLE`. A length of zero goes to `ST_FINISH`. Any other request goes to `ST_LOOKUP`.
- `ST_LOOKUP` compares the page index with the table limit. An index inside the table goes to `ST_ENT_LO`. An index outside it goes to `ST_FINISH`.
- `ST_ENT_LO` reads the frame word and moves to `ST_ENT_HI` on acknowledge.
- `ST_ENT_HI` reads the owner word and moves to `ST_DATA` on acknowledge.
- `ST_DATA` issues the burst. On acknowledge it goes to `ST_FINISH` if that was the last chunk, and otherwise back to `ST_LOOKUP`.
- `ST_FINISH` writes the completion flag and the new count, then returns to `ST_IDLE`.

Top module: `tdma_engine`

## Requirements
- R1: After reset, every channel register, the table base, the table limit and the fault-source register read as zero. `busy` and `mem_req` are low.
- R2: The fault-source register is read-only at 0x010. The table base is at 0x000 and the table limit at 0x008. Channel n word k (k = 0..3) is at 0x100 + 32n + 8k, where k=1 is the flag word, k=2 the count, k=3 the logical address, and k=0 plain storage. An address with nonzero low three bits, or any other address, reads zero and ignores writes.
- R3: Accepting a request clears flag bits 8, 9 and 10 of that channel before any other update.
- R4: If flag bit 0 (enable) is clear, or if `req_to_mem` equals flag bit 1 (1 = memory-to-device), the request is refused. Flag bit 9 is set, bit n of the fault-source register is set and stays set, `busy` stays low, and no memory access is made.
- R5: The number of bytes moved is the smaller of `req_len` and the channel count.
- R6: Before each chunk, two 4-byte reads are made with `mem_we` low: the first at (base + 8*(addr>>12)) masked to its low 31 bits, which returns the frame, and the second at that address + 4. `mem_req` and `mem_addr` are held until `mem_ack`.
- R7: Each data burst targets frame + (addr & 0xFFF). Its length is the smaller of the bytes left and the bytes left in the current page. `mem_we` equals `req_to_mem`.
- R8: When the page index is at least limit/8, the rest of the transfer is dropped with no further memory access.
- R9: `busy` is high from the cycle after acceptance until completion. On completion flag bit 8 is set and the count drops by the clamped length, even if part of the range was dropped.
- R10: When an engine update and a software write hit the same channel word in the same cycle, the engine value is kept. A software write to another word in that cycle still lands.
- R11: A clamped length of zero completes at once with bit 8 set and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Transfer request, taken when busy is low |
| req_chan | input | 2 | Requesting channel |
| req_to_mem | input | 1 | 1 = device data goes into memory |
| req_len | input | 16 | Requested byte length |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | Access writes memory |
| mem_addr | output | 32 | Physical byte address |
| mem_len | output | 16 | Access length in bytes |
| mem_ack | input | 1 | Access accepted and complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Two updates can fall in the same cycle: the engine's write to a channel flag word when it accepts a request, and a software write to that same word. The bench raises a request and a register write to the same flag word on the same clock edge, with the channel disabled, so the engine refuses the request. The word must read back as the refusal value, not the software value. A software write to another channel's count in that same cycle must still land.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ENT_LO,
        ST_ENT_HI,
        ST_DATA,
        ST_FINISH
    } tdma_state_e;

    localparam int FLG_ENABLE  = 0;
    localparam int FLG_TO_DEV  = 1;
    localparam int FLG_TC      = 8;
    localparam int FLG_MEMERR  = 9;
    localparam int FLG_ADDRERR = 10;

    localparam int OFS_TBL_BASE  = 'h000;
    localparam int OFS_TBL_LIMIT = 'h008;
    localparam int OFS_FAULT_SRC = 'h010;
    localparam int OFS_CHAN_BASE = 'h100;

    localparam int WORD_FLAGS = 1;
    localparam int WORD_COUNT = 2;
    localparam int WORD_LADDR = 3;
    localparam int ENTRY_BYTES = 8;

endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
    import tdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int RAW    = 9,
    localparam int CHW   = $clog2(NUM_CH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_we,
    input  logic [RAW-1:0] sw_addr,
    input  logic [AW-1:0]  sw_wdata,
    output logic [AW-1:0]  sw_rdata,
    input  logic           eng_we_flag,
    input  logic           eng_we_cnt,
    input  logic [CHW-1:0] eng_ch,
    input  logic [AW-1:0]  eng_flag_val,
    input  logic [AW-1:0]  eng_cnt_val,
    input  logic [NUM_CH-1:0] eng_nmi_set,
    output logic [AW-1:0]  ch_flags [NUM_CH],
    output logic [AW-1:0]  ch_count [NUM_CH],
    output logic [AW-1:0]  ch_laddr [NUM_CH],
    output logic [AW-1:0]  tbl_base,
    output logic [AW-1:0]  tbl_limit
);

    logic [AW-1:0]     words_q [NUM_CH][4];
    logic [AW-1:0]     base_q, limit_q;
    logic [NUM_CH-1:0] fault_q;

    logic           aligned, ch_hit;
    logic [RAW-1:0] slot;
    logic [CHW-1:0] sw_ch;
    logic [1:0]     sw_k;

    assign aligned = (sw_addr[2:0] == 3'b000);
    assign slot    = (sw_addr - RAW'(OFS_CHAN_BASE)) >> 3;
    assign sw_ch   = slot[2 +: CHW];
    assign sw_k    = slot[1:0];
    assign ch_hit  = aligned && (sw_addr >= RAW'(OFS_CHAN_BASE)) && (slot < RAW'(NUM_CH * 4));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            fault_q <= '0;
        end else begin
            fault_q <= fault_q | eng_nmi_set;
            if (sw_we && aligned && sw_addr == RAW'(OFS_TBL_BASE))  base_q  <= sw_wdata;
            if (sw_we && aligned && sw_addr == RAW'(OFS_TBL_LIMIT)) limit_q <= sw_wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < 4; k++) begin
                if (!rst_n)
                    words_q[c][k] <= '0;
                else if (eng_we_flag && eng_ch == CHW'(c) && k == WORD_FLAGS)
                    words_q[c][k] <= eng_flag_val;
                else if (eng_we_cnt && eng_ch == CHW'(c) && k == WORD_COUNT)
                    words_q[c][k] <= eng_cnt_val;
                else if (sw_we && ch_hit && sw_ch == CHW'(c) && sw_k == 2'(k))
                    words_q[c][k] <= sw_wdata;
            end
        end
    end

    always_comb begin
        sw_rdata = '0;
        if (aligned) begin
            if (sw_addr == RAW'(OFS_TBL_BASE))       sw_rdata = base_q;
            else if (sw_addr == RAW'(OFS_TBL_LIMIT)) sw_rdata = limit_q;
            else if (sw_addr == RAW'(OFS_FAULT_SRC)) sw_rdata = AW'(fault_q);
            else if (ch_hit)                         sw_rdata = words_q[sw_ch][sw_k];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan_out
        assign ch_flags[g] = words_q[g][WORD_FLAGS];
        assign ch_count[g] = words_q[g][WORD_COUNT];
        assign ch_laddr[g] = words_q[g][WORD_LADDR];
    end

    assign tbl_base  = base_q;
    assign tbl_limit = limit_q;

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (($past(fault_q) & ~fault_q) == '0)); // R4

endmodule

// File: rtl/tdma_xfer_fsm.sv
module tdma_xfer_fsm
    import tdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int LW     = 16,
    parameter int PB     = 12,
    localparam int CHW   = $clog2(NUM_CH),
    localparam int PAGE_BYTES = 1 << PB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [CHW-1:0] req_chan,
    input  logic           req_to_mem,
    input  logic [LW-1:0]  req_len,
    input  logic [AW-1:0]  ch_flags [NUM_CH],
    input  logic [AW-1:0]  ch_count [NUM_CH],
    input  logic [AW-1:0]  ch_laddr [NUM_CH],
    input  logic [AW-1:0]  tbl_base,
    input  logic [AW-1:0]  tbl_limit,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [LW-1:0]  mem_len,
    input  logic           mem_ack,
    input  logic [AW-1:0]  mem_rdata,
    output logic           eng_we_flag,
    output logic           eng_we_cnt,
    output logic [CHW-1:0] eng_ch,
    output logic [AW-1:0]  eng_flag_val,
    output logic [AW-1:0]  eng_cnt_val,
    output logic [NUM_CH-1:0] eng_nmi_set
);

    localparam logic [AW-1:0] ENTRY_MASK = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] CLR_MASK   = AW'((1 << FLG_TC) | (1 << FLG_MEMERR) | (1 << FLG_ADDRERR));

    tdma_state_e state_q, state_d;

    logic [CHW-1:0] ch_q;
    logic           to_mem_q;
    logic [LW-1:0]  total_q, remain_q;
    logic [AW-1:0]  laddr_q, frame_q;

    logic [AW-1:0]  sel_flags, sel_count, clean_flags;
    logic           refuse;
    logic [LW-1:0]  clamped;
    logic [AW-1:0]  page_idx, entry_lo, entry_hi;
    logic           idx_ok;
    logic [LW-1:0]  room, chunk;

    assign sel_flags   = ch_flags[req_chan];
    assign sel_count   = ch_count[req_chan];
    assign clean_flags = sel_flags & ~CLR_MASK;
    assign refuse      = !sel_flags[FLG_ENABLE] || (req_to_mem == sel_flags[FLG_TO_DEV]);
    assign clamped     = (AW'(req_len) > sel_count) ? sel_count[LW-1:0] : req_len;

    assign page_idx = laddr_q >> PB;
    assign idx_ok   = page_idx < (tbl_limit >> $clog2(ENTRY_BYTES));
    assign entry_lo = (tbl_base + (page_idx << $clog2(ENTRY_BYTES))) & ENTRY_MASK;
    assign entry_hi = (entry_lo + AW'(4)) & ENTRY_MASK;
    assign room     = LW'(PAGE_BYTES) - LW'(laddr_q[PB-1:0]);
    assign chunk    = (remain_q < room) ? remain_q : room;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && !refuse) state_d = (clamped == '0) ? ST_FINISH : ST_LOOKUP;
            ST_LOOKUP: state_d = idx_ok ? ST_ENT_LO : ST_FINISH;
            ST_ENT_LO: if (mem_ack) state_d = ST_ENT_HI;
            ST_ENT_HI: if (mem_ack) state_d = ST_DATA;
            ST_DATA:   if (mem_ack) state_d = (remain_q == chunk) ? ST_FINISH : ST_LOOKUP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q     <= '0;
            to_mem_q <= 1'b0;
            total_q  <= '0;
            remain_q <= '0;
            laddr_q  <= '0;
            frame_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid && !refuse) begin
                ch_q     <= req_chan;
                to_mem_q <= req_to_mem;
                total_q  <= clamped;
                remain_q <= clamped;
                laddr_q  <= ch_laddr[req_chan];
            end
            if (state_q == ST_ENT_LO && mem_ack) frame_q <= mem_rdata;
            if (state_q == ST_DATA && mem_ack) begin
                remain_q <= remain_q - chunk;
                laddr_q  <= laddr_q + AW'(chunk);
            end
        end
    end

    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_len      = '0;
        eng_we_flag  = 1'b0;
        eng_we_cnt   = 1'b0;
        eng_ch       = ch_q;
        eng_flag_val = '0;
        eng_cnt_val  = '0;
        eng_nmi_set  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                eng_we_flag  = 1'b1;
                eng_ch       = req_chan;
                eng_flag_val = refuse ? (clean_flags | AW'(1 << FLG_MEMERR)) : clean_flags;
                eng_nmi_set[req_chan] = refuse;
            end
            ST_ENT_LO: begin
                mem_req  = 1'b1;
                mem_addr = entry_lo;
                mem_len  = LW'(4);
            end
            ST_ENT_HI: begin
                mem_req  = 1'b1;
                mem_addr = entry_hi;
                mem_len  = LW'(4);
            end
            ST_DATA: begin
                mem_req  = 1'b1;
                mem_we   = to_mem_q;
                mem_addr = frame_q + AW'(laddr_q[PB-1:0]);
                mem_len  = chunk;
            end
            ST_FINISH: begin
                eng_we_flag  = 1'b1;
                eng_flag_val = ch_flags[ch_q] | AW'(1 << FLG_TC);
                eng_we_cnt   = 1'b1;
                eng_cnt_val  = ch_count[ch_q] - AW'(total_q);
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6
    AST_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && (state_q == ST_ENT_LO || state_q == ST_ENT_HI)) |-> !mem_addr[AW-1]); // R6
    AST_PAGE_FIT: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> ((32'(mem_addr[PB-1:0]) + 32'(mem_len)) <= 32'(PAGE_BYTES))); // R7
    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_FINISH) |=> !busy); // R9

endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
    import tdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 16,
    parameter int REG_AW = 9,
    localparam int AW    = 32,
    localparam int CHW   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              req_valid,
    input  logic [CHW-1:0]    req_chan,
    input  logic              req_to_mem,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_ack,
    input  logic [AW-1:0]     mem_rdata
);

    logic [AW-1:0]     ch_flags [NUM_CH];
    logic [AW-1:0]     ch_count [NUM_CH];
    logic [AW-1:0]     ch_laddr [NUM_CH];
    logic [AW-1:0]     tbl_base, tbl_limit;
    logic              eng_we_flag, eng_we_cnt;
    logic [CHW-1:0]    eng_ch;
    logic [AW-1:0]     eng_flag_val, eng_cnt_val;
    logic [NUM_CH-1:0] eng_nmi_set;

    tdma_regs #(.NUM_CH(NUM_CH), .AW(AW), .RAW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
        .eng_we_flag(eng_we_flag), .eng_we_cnt(eng_we_cnt), .eng_ch(eng_ch),
        .eng_flag_val(eng_flag_val), .eng_cnt_val(eng_cnt_val), .eng_nmi_set(eng_nmi_set),
        .ch_flags(ch_flags), .ch_count(ch_count), .ch_laddr(ch_laddr),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit)
    );

    tdma_xfer_fsm #(.NUM_CH(NUM_CH), .AW(AW), .LW(LEN_W), .PB(12)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_chan(req_chan), .req_to_mem(req_to_mem), .req_len(req_len),
        .ch_flags(ch_flags), .ch_count(ch_count), .ch_laddr(ch_laddr),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .eng_we_flag(eng_we_flag), .eng_we_cnt(eng_we_cnt), .eng_ch(eng_ch),
        .eng_flag_val(eng_flag_val), .eng_cnt_val(eng_cnt_val), .eng_nmi_set(eng_nmi_set)
    );

endmodule

// File: tb/tdma_engine_tb.sv
`timescale 1ns/1ps
module tdma_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        req_to_mem = 1'b0;
    logic [15:0] req_len = '0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_len;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    tdma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_chan(req_chan), .req_to_mem(req_to_mem),
        .req_len(req_len), .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic finished = 1'b0;

    logic [31:0] log_a [32];
    logic [15:0] log_l [32];
    logic        log_w [32];
    int          log_n = 0;
    logic [31:0] exp_a [32];
    logic [15:0] exp_l [32];
    logic        exp_w [32];
    int          exp_n;

    function automatic logic [31:0] frame_of(input logic [31:0] a);
        return {a[19:0], 12'h000} ^ 32'h8000_0000;
    endfunction

    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            mem_rdata = frame_of(mem_addr);
            if (log_n < 32) begin
                log_a[log_n] = mem_addr;
                log_l[log_n] = mem_len;
                log_w[log_n] = mem_we;
            end
            log_n = log_n + 1;
        end else begin
            mem_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic issue(input logic [1:0] c, input logic tm, input logic [15:0] l);
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_chan = c; req_to_mem = tm; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic build_expected(input logic [31:0] base, input logic [31:0] limit,
                                  input logic [31:0] la, input logic [31:0] len, input logic tm);
        logic [31:0] a, rem, idx, e, fr, ch, room;
        a = la; rem = len; exp_n = 0;
        while (rem != 0 && exp_n < 30) begin
            idx = a >> 12;
            if (idx >= (limit >> 3)) break;
            e = (base + idx * 8) & 32'h7FFF_FFFF;
            fr = frame_of(e);
            room = 32'h1000 - (a & 32'hFFF);
            ch = (rem < room) ? rem : room;
            exp_a[exp_n] = e;                      exp_l[exp_n] = 16'd4;      exp_w[exp_n] = 1'b0; exp_n++;
            exp_a[exp_n] = (e + 4) & 32'h7FFF_FFFF; exp_l[exp_n] = 16'd4;      exp_w[exp_n] = 1'b0; exp_n++;
            exp_a[exp_n] = fr + (a & 32'hFFF);     exp_l[exp_n] = ch[15:0];   exp_w[exp_n] = tm;   exp_n++;
            rem = rem - ch; a = a + ch;
        end
    endtask

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] flags;
        logic [31:0] count;
        logic [31:0] laddr;
        logic        to_mem;
        logic [15:0] len;
        logic [31:0] base;
        logic [31:0] limit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 32'h1,   32'd1000,   32'h0000_0010, 1'b1, 16'd100,    32'h0000_8000, 32'h100},
        '{2'd1, 32'h3,   32'h1800,   32'h0000_0F00, 1'b0, 16'h2000,   32'h8000_9000, 32'h100},
        '{2'd2, 32'h1,   32'd10,     32'h0,         1'b0, 16'd10,     32'h0000_8000, 32'h100},
        '{2'd3, 32'h2,   32'd10,     32'h0,         1'b0, 16'd10,     32'h0000_8000, 32'h100},
        '{2'd3, 32'h701, 32'd8,      32'h0000_3FF8, 1'b1, 16'd8,      32'h0000_8000, 32'h100},
        '{2'd0, 32'h1,   32'd0,      32'h0000_0020, 1'b1, 16'd50,     32'h0000_8000, 32'h100},
        '{2'd1, 32'h3,   32'h1000,   32'h0000_2F00, 1'b0, 16'h400,    32'h0000_8000, 32'd24},
        '{2'd2, 32'h1,   32'h100,    32'h0000_5000, 1'b1, 16'h80,     32'h0000_8000, 32'd40}
    };

    initial begin
        logic [31:0] rd, exp_nmi, clamp, exp_flags;
        logic bad;
        exp_nmi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
        rd_reg(9'h000, rd); chk("R1 base", rd, 32'h0);
        rd_reg(9'h010, rd); chk("R1 fault", rd, 32'h0);
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 4; k++) begin
                rd_reg(9'(9'h100 + c * 32 + k * 8), rd);
                chk("R1 channel word", rd, 32'h0);
            end
        end

        // R2: map, storage word, unmapped, read-only fault source
        wr_reg(9'h140, 32'hCAFE_0001); rd_reg(9'h140, rd); chk("R2 word0 storage", rd, 32'hCAFE_0001);
        wr_reg(9'h158, 32'h1234_5678); rd_reg(9'h158, rd); chk("R2 ch2 laddr", rd, 32'h1234_5678);
        wr_reg(9'h020, 32'hFFFF_FFFF); rd_reg(9'h020, rd); chk("R2 unmapped", rd, 32'h0);
        wr_reg(9'h15C, 32'hFFFF_FFFF); rd_reg(9'h158, rd); chk("R2 misaligned ignored", rd, 32'h1234_5678);
        wr_reg(9'h010, 32'hF); rd_reg(9'h010, rd); chk("R2 fault read-only", rd, 32'h0);

        for (int v = 0; v < 8; v++) begin
            vec_t t;
            t = VECS[v];
            wr_reg(9'h000, t.base);
            wr_reg(9'h008, t.limit);
            wr_reg(9'(9'h108 + t.ch * 32), t.flags);
            wr_reg(9'(9'h110 + t.ch * 32), t.count);
            wr_reg(9'(9'h118 + t.ch * 32), t.laddr);
            bad = !t.flags[0] || (t.to_mem == t.flags[1]);
            clamp = ({16'b0, t.len} > t.count) ? t.count : {16'b0, t.len};
            issue(t.ch, t.to_mem, t.len);
            chk("R9/R4 busy after accept", {31'b0, busy}, {31'b0, !bad});
            wait_idle();
            if (bad) begin
                build_expected(t.base, t.limit, t.laddr, 0, t.to_mem);
                exp_nmi = exp_nmi | (32'h1 << t.ch);
                exp_flags = (t.flags & ~32'h700) | 32'h200;
            end else begin
                build_expected(t.base, t.limit, t.laddr, clamp, t.to_mem);
                exp_flags = (t.flags & ~32'h700) | 32'h100;
            end
            chk("R6/R8/R11 access count", log_n, exp_n);
            for (int i = 0; i < exp_n && i < log_n; i++) begin
                chk("R6/R7 access addr", log_a[i], exp_a[i]);
                chk("R7/R5 access len", {16'b0, log_l[i]}, {16'b0, exp_l[i]});
                chk("R7 access dir", {31'b0, log_w[i]}, {31'b0, exp_w[i]});
            end
            rd_reg(9'(9'h108 + t.ch * 32), rd); chk("R3/R4/R9 flags", rd, exp_flags);
            rd_reg(9'(9'h110 + t.ch * 32), rd); chk("R5/R9 count", rd, bad ? t.count : t.count - clamp);
            rd_reg(9'h010, rd); chk("R4 fault source", rd, exp_nmi);
        end

        // R10: engine refusal and software write hit channel 0 flags in the same cycle
        wr_reg(9'h108, 32'h0);
        @(negedge clk);
        log_n = 0;
        reg_we = 1'b1; reg_addr = 9'h108; reg_wdata = 32'h3;
        req_valid = 1'b1; req_chan = 2'd0; req_to_mem = 1'b1; req_len = 16'd4;
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0;
        rd_reg(9'h108, rd); chk("R10 engine wins flags", rd, 32'h200);
        chk("R10 no traffic", log_n, 0);
        wr_reg(9'h108, 32'h0);
        wr_reg(9'h128, 32'h1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 9'h130; reg_wdata = 32'h55;
        req_valid = 1'b1; req_chan = 2'd0; req_to_mem = 1'b1; req_len = 16'd4;
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0;
        rd_reg(9'h130, rd); chk("R10 other word lands", rd, 32'h55);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule